// File: doc/BRIEF.md
# PHY Control-Register Port Master

This block is the hardware side of an indirect register port into a PHY. A client asks for a register write, which carries an address and a data word, or for a register read, which carries only an address. The master turns each request into a fixed chain of strobe phases on the PHY side. It drives a 16-bit data bus and four single-bit strobes: load-address, load-data, read and write. On each strobe it completes a four-phase level handshake against the PHY's acknowledge line.

Every wait and every pause is counted in microsecond ticks. A prescaler makes the tick from the clock frequency, which is a parameter. A wait for an acknowledge edge gives up after a bounded number of ticks. When that happens the master raises a sticky timeout flag and still finishes the chain. After the last strobe of a read, the master takes the result from the PHY status word, from the field just above the acknowledge bit.

The client side has no handshake. While `busy` is high, new requests are dropped. At the end of each operation the master gives a one-cycle `done` pulse, holds the read data, and shows the timeout flag.

Top module: `cregport_master`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `timeout`, every strobe and `phy_din` are all low, and `rd_data` is zero.
- R2: A write request drives exactly three strobes, in this order: load-address with `phy_din` equal to the address, then load-data with `phy_din` equal to the write data, then write with the write data still on `phy_din`.
- R3: A read request drives load-address with the address on `phy_din`, then load-data with `phy_din` at zero, then read. When `done` pulses, `rd_data` holds status bits [ACK_POS+16:ACK_POS+1] as they were at the end of the read strobe. The acknowledge is status bit ACK_POS, which is 0 by default.
- R4: Each strobe is raised only while acknowledge is low. It stays high until acknowledge is seen high, and only one strobe is high at a time.
- R5: A strobe drops EDGE_GAP ticks after acknowledge rises. The next strobe, or the end of the operation, comes EDGE_GAP plus SETTLE_GAP ticks after acknowledge falls. A tick is CLK_MHZ clock cycles.
- R6: If acknowledge never answers, each strobe stays high for ACK_TMO plus EDGE_GAP ticks.
- R7: A wait that runs out sets `timeout`, and the operation still completes with all three strobes and a `done` pulse.
- R8: Before the address phase and before the data phase, `phy_din` is cleared to zero with no strobe high, and only then is the new value loaded.
- R9: `busy` is high from the cycle after a request is accepted through the `done` cycle. A request that arrives while `busy` is high has no effect on the strobes or on `phy_din`.
- R10: `timeout` stays set until the next request is accepted, and it is low in the cycle after that acceptance.
- R11: `done` is high for exactly one cycle per operation. A write operation leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe; taken only while idle |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data returned by the last read |
| timeout | output | 1 | Sticky flag: a handshake wait ran out |
| phy_din | output | 16 | Data bus to the PHY port |
| phy_cap_addr | output | 1 | Load-address strobe |
| phy_cap_data | output | 1 | Load-data strobe |
| phy_rd | output | 1 | Read strobe |
| phy_wr | output | 1 | Write strobe |
| phy_stat | input | 17 | PHY status: acknowledge at bit ACK_POS, data field directly above it |

## Verification
A responder models the PHY. It answers each strobe after a delay of zero to three cycles, and the delay changes from one operation to the next. Writes sweep all sixteen low-address slots with distinct data. Reads of the untouched initial contents and reads after the writes then show that the address and data reach the right strobe, and that the returned field is taken from the right bit positions. A responder that never acknowledges tells a correct timeout apart from a hang or a silent skip, and the read that follows shows the flag being cleared. A request injected in the middle of an operation shows that requests are dropped while busy. The gap and strobe-width windows are measured in cycles, which separates the edge pause from the settle pause and checks the tick prescaler.

// File: rtl/cregport_pkg.sv
package cregport_pkg;

    localparam int STB_N = 4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CLEAR,
        S_LOAD,
        S_RAISE,
        S_HOLD_HI,
        S_DROP,
        S_HOLD_LO,
        S_SETTLE,
        S_FINISH
    } seq_state_e;

    // Strobe index; bit position on the strobe vector
    typedef enum logic [1:0] {
        STB_ADDR = 2'd0,
        STB_DATA = 2'd1,
        STB_RD   = 2'd2,
        STB_WR   = 2'd3
    } strobe_e;

    typedef struct packed {
        logic wr;
        logic data_phase;
        logic second;
    } op_ctx_t;

    function automatic strobe_e pick_strobe(op_ctx_t c);
        if (!c.data_phase) return STB_ADDR;
        if (!c.second)     return STB_DATA;
        return c.wr ? STB_WR : STB_RD;
    endfunction

    function automatic logic [STB_N-1:0] strobe_vec(strobe_e s);
        return STB_N'(1) << s;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/cregport_prescale.sv
module cregport_prescale #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_passthru
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            logic [PW-1:0] pre_q;

            always_ff @(posedge clk) begin
                if (rst || clear)             pre_q <= '0;
                else if (pre_q == PW'(DIV-1)) pre_q <= '0;
                else                          pre_q <= pre_q + 1'b1;
            end

            assign tick = (pre_q == PW'(DIV-1));

            a_r5_tick_spacing: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/cregport_timer.sv
module cregport_timer #(
    parameter int DIV   = 100,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic             tick;
    logic [CNT_W-1:0] cnt_q;

    cregport_prescale #(.DIV(DIV)) i_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (restart),
        .tick  (tick)
    );

    assign expired = (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || restart)         cnt_q <= '0;
        else if (tick && !expired)  cnt_q <= cnt_q + 1'b1;
    end

    // R6: tick count never runs past the window of the current state
    a_r6_cnt_in_window: assert property (@(posedge clk) disable iff (rst)
        !restart |-> cnt_q <= limit);
endmodule

// File: rtl/cregport_seq.sv
module cregport_seq
    import cregport_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ACK_POS   = 0,
    parameter int CNT_W     = 8,
    parameter int ACK_TMO   = 100,
    parameter int EDGE_GAP  = 5,
    parameter int SETTLE_GAP = 50
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [DATA_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     timeout,
    output logic [DATA_W-1:0]        phy_din,
    output logic [STB_N-1:0]         phy_stb,
    input  logic [ACK_POS+DATA_W:0]  phy_stat,
    input  logic                     tmr_expired,
    output logic                     tmr_restart,
    output logic [CNT_W-1:0]         tmr_limit
);
    seq_state_e         state_q, state_d;
    op_ctx_t            ctx_q, ctx_d;
    logic [DATA_W-1:0]  addr_q, wdata_q, din_q, rd_q;
    logic [STB_N-1:0]   stb_q;
    logic               tmo_q;
    logic               ack, accept, tmo_hit, last_done;
    logic [DATA_W-1:0]  rsp;

    assign ack       = phy_stat[ACK_POS];
    assign rsp       = phy_stat[ACK_POS+DATA_W:ACK_POS+1];
    assign accept    = (state_q == S_IDLE) && req_valid;
    assign last_done = (state_q == S_SETTLE) && tmr_expired
                       && ctx_q.data_phase && ctx_q.second;

    // Next-state and context sequencing
    always_comb begin
        state_d = state_q;
        ctx_d   = ctx_q;
        tmo_hit = 1'b0;
        case (state_q)
            S_IDLE: if (accept) begin
                state_d = S_CLEAR;
                ctx_d   = '{wr: req_write, data_phase: 1'b0, second: 1'b0};
            end
            S_CLEAR: state_d = S_LOAD;
            S_LOAD:  state_d = S_RAISE;
            S_RAISE: if (ack || tmr_expired) begin
                state_d = S_HOLD_HI;
                tmo_hit = !ack;
            end
            S_HOLD_HI: if (tmr_expired) state_d = S_DROP;
            S_DROP: if (!ack || tmr_expired) begin
                state_d = S_HOLD_LO;
                tmo_hit = ack;
            end
            S_HOLD_LO: if (tmr_expired) state_d = S_SETTLE;
            S_SETTLE: if (tmr_expired) begin
                if (!ctx_q.data_phase) begin
                    state_d          = S_CLEAR;
                    ctx_d.data_phase = 1'b1;
                    ctx_d.second     = 1'b0;
                end else if (!ctx_q.second) begin
                    state_d      = S_RAISE;
                    ctx_d.second = 1'b1;
                end else begin
                    state_d = S_FINISH;
                end
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Wait window for each timed state, in ticks
    always_comb begin
        case (state_q)
            S_RAISE, S_DROP:      tmr_limit = CNT_W'(ACK_TMO);
            S_HOLD_HI, S_HOLD_LO: tmr_limit = CNT_W'(EDGE_GAP);
            S_SETTLE:             tmr_limit = CNT_W'(SETTLE_GAP);
            default:              tmr_limit = '0;
        endcase
    end

    assign tmr_restart = (state_q != state_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            ctx_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            din_q   <= '0;
            stb_q   <= '0;
            rd_q    <= '0;
            tmo_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ctx_q   <= ctx_d;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (state_d == S_CLEAR)
                din_q <= '0;
            else if (state_q == S_CLEAR)
                din_q <= !ctx_q.data_phase ? addr_q
                       : (ctx_q.wr ? wdata_q : '0);
            if (state_d == S_RAISE || state_d == S_HOLD_HI)
                stb_q <= strobe_vec(pick_strobe(ctx_d));
            else
                stb_q <= '0;
            if (last_done && !ctx_q.wr)
                rd_q <= rsp;
            if (accept)       tmo_q <= 1'b0;
            else if (tmo_hit) tmo_q <= 1'b1;
        end
    end

    assign busy    = (state_q != S_IDLE);
    assign done    = (state_q == S_FINISH);
    assign rd_data = rd_q;
    assign timeout = tmo_q;
    assign phy_din = din_q;
    assign phy_stb = stb_q;

    a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stb_q));
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> stb_q == '0);
    a_r8_din_steady_under_strobe: assert property (@(posedge clk) disable iff (rst)
        (|stb_q) |-> $stable(din_q));
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r10_timeout_sticky: assert property (@(posedge clk) disable iff (rst)
        (tmo_q && !accept) |=> tmo_q);
    a_r10_accept_clears: assert property (@(posedge clk) disable iff (rst)
        accept |=> !tmo_q);
endmodule

// File: rtl/cregport_master.sv
module cregport_master
    import cregport_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int ACK_POS    = 0,
    parameter int CLK_MHZ    = 100,
    parameter int ACK_TMO    = 100,
    parameter int EDGE_GAP   = 5,
    parameter int SETTLE_GAP = 50
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [DATA_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    busy,
    output logic                    done,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    timeout,
    output logic [DATA_W-1:0]       phy_din,
    output logic                    phy_cap_addr,
    output logic                    phy_cap_data,
    output logic                    phy_rd,
    output logic                    phy_wr,
    input  logic [ACK_POS+DATA_W:0] phy_stat
);
    localparam int unsigned MAX_WIN = max3(ACK_TMO, EDGE_GAP, SETTLE_GAP);
    localparam int CNT_W = $clog2(MAX_WIN + 1);

    logic             tmr_expired, tmr_restart;
    logic [CNT_W-1:0] tmr_limit;
    logic [STB_N-1:0] stb;

    cregport_timer #(.DIV(CLK_MHZ), .CNT_W(CNT_W)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (tmr_restart),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

    cregport_seq #(
        .DATA_W(DATA_W), .ACK_POS(ACK_POS), .CNT_W(CNT_W),
        .ACK_TMO(ACK_TMO), .EDGE_GAP(EDGE_GAP), .SETTLE_GAP(SETTLE_GAP)
    ) i_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .busy        (busy),
        .done        (done),
        .rd_data     (rd_data),
        .timeout     (timeout),
        .phy_din     (phy_din),
        .phy_stb     (stb),
        .phy_stat    (phy_stat),
        .tmr_expired (tmr_expired),
        .tmr_restart (tmr_restart),
        .tmr_limit   (tmr_limit)
    );

    assign phy_cap_addr = stb[STB_ADDR];
    assign phy_cap_data = stb[STB_DATA];
    assign phy_rd       = stb[STB_RD];
    assign phy_wr       = stb[STB_WR];
endmodule

// File: tb/test_cregport_master.sv
module test_cregport_master;
    localparam int CLK_PERIOD = 10;
    localparam int DIV  = 3;
    localparam int TMO  = 10;
    localparam int EDG  = 2;
    localparam int STL  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        busy, done, timeout;
    logic [15:0] rd_data, phy_din;
    logic        phy_cap_addr, phy_cap_data, phy_rd, phy_wr;
    logic [16:0] phy_stat;

    always #(CLK_PERIOD/2) clk = ~clk;

    cregport_master #(
        .DATA_W(16), .ACK_POS(0), .CLK_MHZ(DIV),
        .ACK_TMO(TMO), .EDGE_GAP(EDG), .SETTLE_GAP(STL)
    ) i_cregport_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .timeout(timeout), .phy_din(phy_din),
        .phy_cap_addr(phy_cap_addr), .phy_cap_data(phy_cap_data),
        .phy_rd(phy_rd), .phy_wr(phy_wr), .phy_stat(phy_stat)
    );

    int vectors = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- PHY responder and monitor ----------------
    logic [15:0] mem [16];
    logic [15:0] shadow [16];
    logic [15:0] a_lat = '0, d_lat = '0, dout = '0;
    logic        ack_r = 1'b0;
    int          dly = 0, dly_cnt = 0;
    bit          dead = 0;
    logic [3:0]  stb_prev = '0;
    logic        ack_prev = 1'b0;
    int          cyc = 0, t_ar = 0, t_af = 0, t_rise = 0;
    bit          have_af = 0, zero_seen = 0;
    int          ev_cnt = 0, hs_err = 0, gap_err = 0;
    int          ev_kind [8];
    logic [15:0] ev_din [8];
    bit          ev_clr [8];

    assign phy_stat = {dout, ack_r};

    always @(negedge clk) begin
        logic [3:0] stb;
        int len;
        stb = {phy_wr, phy_rd, phy_cap_data, phy_cap_addr};
        cyc++;
        if (ack_r && !ack_prev) t_ar = cyc;
        if (!ack_r && ack_prev) begin t_af = cyc; have_af = 1; end
        if (stb == 0 && phy_din == 0) zero_seen = 1;
        if (stb_prev == 0 && stb != 0) begin
            int k = 0;
            for (int b = 0; b < 4; b++) if (stb[b]) k = b;
            if (ev_cnt < 8) begin
                ev_kind[ev_cnt] = k; ev_din[ev_cnt] = phy_din; ev_clr[ev_cnt] = zero_seen;
            end
            ev_cnt++;
            zero_seen = 0;
            t_rise = cyc;
            if (ack_r) hs_err++;                       // R4
            if (have_af && !dead) begin                // R5 fall-to-next window
                len = cyc - t_af;
                if (len < (EDG+STL)*DIV || len > (EDG+STL)*DIV + 4) gap_err++;
            end
            have_af = 0;
            case (k)
                0: a_lat = phy_din;
                1: d_lat = phy_din;
                2: dout  = mem[a_lat[3:0]];
                default: mem[a_lat[3:0]] = d_lat;
            endcase
        end
        if (stb_prev != 0 && stb == 0) begin
            if (!dead) begin
                if (!ack_r) hs_err++;                  // R4
                len = cyc - t_ar;                      // R5 rise-to-drop window
                if (len < EDG*DIV || len > EDG*DIV + 3) gap_err++;
            end else begin
                len = cyc - t_rise;                    // R6 strobe width on timeout
                if (len < (TMO+EDG)*DIV || len > (TMO+EDG)*DIV + 4) gap_err++;
            end
        end
        stb_prev = stb;
        ack_prev = ack_r;
        if (!dead && ((stb != 0) != ack_r)) begin
            if (dly_cnt >= dly) begin ack_r = (stb != 0); dly_cnt = 0; end
            else dly_cnt++;
        end else dly_cnt = 0;
    end

    // ---------------- operation task ----------------
    task automatic do_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                         input int dl, input bit dead_m, input bit poke);
        logic [15:0] rd_before, exp_rd;
        int n;
        bit got;
        @(negedge clk);
        dly = dl; dead = dead_m; ev_cnt = 0; hs_err = 0; gap_err = 0; have_af = 0;
        rd_before = rd_data;
        exp_rd = shadow[a[3:0]];
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        chk(busy == 1, "R9 busy after accept", busy, 1);
        chk(timeout == 0, "R10 timeout cleared on accept", timeout, 0);
        got = 0;
        for (n = 0; n < 3000 && !got; n++) begin
            if (poke && n == 4) begin
                req_valid = 1; req_write = ~wr; req_addr = 16'hBEEF; req_wdata = 16'h7777;
            end else req_valid = 0;
            @(negedge clk);
            if (done) got = 1;
        end
        req_valid = 0;
        chk(got, "R7 operation reached done", got, 1);
        chk(busy == 1, "R9 busy during done", busy, 1);
        @(negedge clk);
        chk(done == 0, "R11 done one cycle", done, 0);
        chk(busy == 0, "R9 busy drops after done", busy, 0);
        chk(ev_cnt == 3, "R2/R3 strobe count", ev_cnt, 3);
        chk(ev_kind[0] == 0 && ev_din[0] == a, "R2 R3 address phase", {ev_kind[0][15:0], ev_din[0]}, {16'd0, a});
        chk(ev_kind[1] == 1 && ev_din[1] == (wr ? d : 16'h0), "R2 R3 load-data phase",
            {ev_kind[1][15:0], ev_din[1]}, {16'd1, (wr ? d : 16'h0)});
        chk(ev_kind[2] == (wr ? 3 : 2) && ev_din[2] == ev_din[1], "R2 R3 final strobe",
            {ev_kind[2][15:0], ev_din[2]}, {(wr ? 16'd3 : 16'd2), ev_din[1]});
        chk(ev_clr[0] && ev_clr[1], "R8 bus cleared before phase", {ev_clr[0], ev_clr[1]}, 2'b11);
        chk(hs_err == 0, "R4 handshake order", hs_err, 0);
        chk(gap_err == 0, dead_m ? "R6 timeout strobe width" : "R5 gap windows", gap_err, 0);
        chk(timeout == dead_m, "R7 timeout flag", timeout, dead_m);
        if (wr) begin
            chk(rd_data == rd_before, "R11 write keeps rd_data", rd_data, rd_before);
            shadow[a[3:0]] = d;
        end else begin
            chk(rd_data == exp_rd, "R3 read data field", rd_data, exp_rd);
        end
        dead = 0; ack_r = 0;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i]    = 16'hC3A0 + 16'(i) * 16'h0101;
            shadow[i] = 16'hC3A0 + 16'(i) * 16'h0101;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && timeout == 0, "R1 reset flags", {busy, done, timeout}, 0);
        chk({phy_wr, phy_rd, phy_cap_data, phy_cap_addr} == 0, "R1 reset strobes",
            {phy_wr, phy_rd, phy_cap_data, phy_cap_addr}, 0);
        chk(phy_din == 0 && rd_data == 0, "R1 reset buses", {phy_din, rd_data}, 0);

        for (int i = 0; i < 4; i++)
            do_op(0, 16'h4300 + 16'(i), 16'h0, i, 0, 0);
        for (int i = 0; i < 16; i++)
            do_op(1, 16'h1200 + 16'(i) * 16'h0110 + 16'(i), 16'hF00F ^ (16'(i) * 16'h1111),
                  i % 4, 0, i == 5);
        for (int i = 0; i < 16; i++)
            do_op(0, 16'h8800 + 16'(15 - i), 16'h0, (i + 1) % 4, 0, i == 9);
        // R7 R10: unresponsive PHY, then recovery
        do_op(1, 16'h0A0B, 16'h3C3C, 0, 1, 0);
        do_op(0, 16'h000B, 16'h0, 2, 0, 0);
        chk(timeout == 0, "R10 timeout stays clear after good op", timeout, 0);
        finish_run();
    end
endmodule